// File: doc/BRIEF.md
# Interrupt Priority Resolver with Acceptance Latch

This block sits between the per-group interrupt request logic and the processor core. Each interrupt group supplies a 4-bit request vector, a 4-bit enable vector and a 3-bit priority level. Every cycle, the block searches the maskable groups (2 to 30) for the group with the best priority. A group counts as a candidate only when at least one of its request bits is set together with the matching enable bit. The block presents the winner's group number combinationally. It presents the winner's level on a registered output, which the processor compares with its own interrupt mask.

When the processor takes an interrupt, it pulses an acknowledge strobe and returns the level it accepted. The block then stores the winning group number in an accepted-group register. Software reads this register through a small byte-addressed read port, and the value serves as a vector offset. If the acknowledged level does not match the winner's level at that moment, a sticky mismatch flag is raised. The flag stays set until reset.

Top module: `irq_priority_arbiter`

## Requirements
- R1: Group g is a candidate only when (req[g] & en[g]) != 0. Groups 0 and 1 never win, whatever their inputs are.
- R2: Among candidates, the numerically lowest level wins.
- R3: When no candidate has a level below 7, `win_group` is 0 and the winner level is 7. Level 7 therefore never wins.
- R4: When candidates tie on the best level, the lowest group number wins.
- R5: `level_out` equals the winner's level one clock after the inputs change, and reads 7 during and just after reset.
- R6: On a clock edge with `ack_valid` high, the accepted-group register loads the current `win_group`. It resets to 0.
- R7: Reading offset 0 returns {accepted group, 2'b00} when that group still has a nonzero (req & en). Otherwise it returns 0.
- R8: Every nonzero read offset returns 0.
- R9: `ack_mismatch` sets on an acknowledge whose `ack_level` differs from the current winner's level. It holds until reset. An acknowledge with a matching level leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vec | input | 124 | Request bits, 4 per group; group g at bits [4g+3:4g] |
| en_vec | input | 124 | Enable bits, same layout as req_vec |
| lvl_vec | input | 87 | 3-bit level per group 2..30; group g at bits [3(g-2)+2:3(g-2)] |
| ack_valid | input | 1 | Processor acceptance strobe |
| ack_level | input | 3 | Level the processor accepted |
| rd_addr | input | 3 | Byte offset into the accepted-group register |
| win_group | output | 5 | Current winning group (0 = none) |
| level_out | output | 3 | Registered winner level (7 = none) |
| rd_data | output | 8 | Read data for rd_addr |
| ack_mismatch | output | 1 | Sticky acknowledge level mismatch flag |

## Verification
The hardest case to reach from the ports is an accepted group whose request disappears after the acknowledge. This needs a clean acknowledge, and then the request inputs must change while the latched register keeps its value. The bench acknowledges a winner with the matching level and reads offset 0 to see the shifted group number. It then clears that group's request, leaves the rest unchanged, and reads offset 0 again, expecting zero. A second hard case is a mismatch that must survive later matching acknowledges. The bench acknowledges with a wrong level while idle, then acknowledges correctly, and checks that the flag is still set.

// File: rtl/irq_pri_pkg.sv
package irq_pri_pkg;
  // A group takes part only when some request lane is also enabled
  function automatic logic has_candidate(input logic [7:0] req, input logic [7:0] en);
    return |(req & en);
  endfunction

  // Strictly-lower wins; equal keeps the earlier (lower-numbered) group
  function automatic logic level_beats(input logic [7:0] cand, input logic [7:0] cur);
    return cand < cur;
  endfunction

  // Accepted-group byte: group number scaled to a 4-byte vector step
  function automatic logic [7:0] vector_byte(input logic [7:0] grp);
    return grp << 2;
  endfunction
endpackage

// File: rtl/irq_pri_search.sv
module irq_pri_search
  import irq_pri_pkg::*;
#(
  parameter int NUM_GROUPS  = 31,
  parameter int FIRST_GROUP = 2,
  parameter int LANES       = 4,
  parameter int LVL_W       = 3,
  localparam int GW         = $clog2(NUM_GROUPS),
  localparam int NSRC       = NUM_GROUPS - FIRST_GROUP
) (
  input  logic [NUM_GROUPS*LANES-1:0] req_vec,
  input  logic [NUM_GROUPS*LANES-1:0] en_vec,
  input  logic [NSRC*LVL_W-1:0]       lvl_vec,
  output logic [GW-1:0]               best_group,
  output logic [LVL_W-1:0]            best_level
);
  localparam logic [LVL_W-1:0] IDLE_LVL = {LVL_W{1'b1}};

  logic [NSRC:0][GW-1:0]    grp_chain;
  logic [NSRC:0][LVL_W-1:0] lvl_chain;
  logic [NSRC-1:0]          take;

  assign grp_chain[0] = '0;
  assign lvl_chain[0] = IDLE_LVL;

  for (genvar k = 0; k < NSRC; k++) begin : g_stage
    localparam int G = k + FIRST_GROUP;
    logic [LVL_W-1:0] my_lvl;
    assign my_lvl  = lvl_vec[k*LVL_W +: LVL_W];
    assign take[k] = has_candidate(8'(req_vec[G*LANES +: LANES]), 8'(en_vec[G*LANES +: LANES]))
                   && level_beats(8'(my_lvl), 8'(lvl_chain[k]));
    assign grp_chain[k+1] = take[k] ? GW'(G) : grp_chain[k];
    assign lvl_chain[k+1] = take[k] ? my_lvl : lvl_chain[k];
  end

  assign best_group = grp_chain[NSRC];
  assign best_level = lvl_chain[NSRC];
endmodule

// File: rtl/irq_pri_accept.sv
module irq_pri_accept #(
  parameter int GW    = 5,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GW-1:0]    best_group,
  input  logic [LVL_W-1:0] best_level,
  input  logic             ack_valid,
  input  logic [LVL_W-1:0] ack_level,
  output logic [LVL_W-1:0] level_q,
  output logic [GW-1:0]    accepted_q,
  output logic             mismatch_q
);
  logic ack_bad;
  assign ack_bad = ack_valid && (ack_level != best_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q    <= {LVL_W{1'b1}};
      accepted_q <= '0;
      mismatch_q <= 1'b0;
    end else begin
      level_q <= best_level;
      if (ack_valid) accepted_q <= best_group;
      if (ack_bad) mismatch_q <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_pri_readback.sv
module irq_pri_readback
  import irq_pri_pkg::*;
#(
  parameter int NUM_GROUPS = 31,
  parameter int LANES      = 4,
  parameter int AW         = 3,
  localparam int GW        = $clog2(NUM_GROUPS)
) (
  input  logic [NUM_GROUPS*LANES-1:0] req_vec,
  input  logic [NUM_GROUPS*LANES-1:0] en_vec,
  input  logic [GW-1:0]               accepted,
  input  logic [AW-1:0]               rd_addr,
  output logic [7:0]                  rd_data
);
  logic still_pending;

  always_comb begin
    still_pending = 1'b0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (accepted == GW'(g))
        still_pending = has_candidate(8'(req_vec[g*LANES +: LANES]), 8'(en_vec[g*LANES +: LANES]));
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == '0 && still_pending) rd_data = vector_byte(8'(accepted));
  end
endmodule

// File: rtl/irq_priority_arbiter.sv
module irq_priority_arbiter #(
  parameter int NUM_GROUPS  = 31,
  parameter int FIRST_GROUP = 2,
  parameter int LANES       = 4,
  parameter int LVL_W       = 3,
  parameter int AW          = 3,
  localparam int GW         = $clog2(NUM_GROUPS),
  localparam int NSRC       = NUM_GROUPS - FIRST_GROUP
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_GROUPS*LANES-1:0] req_vec,
  input  logic [NUM_GROUPS*LANES-1:0] en_vec,
  input  logic [NSRC*LVL_W-1:0]       lvl_vec,
  input  logic                        ack_valid,
  input  logic [LVL_W-1:0]            ack_level,
  input  logic [AW-1:0]               rd_addr,
  output logic [GW-1:0]               win_group,
  output logic [LVL_W-1:0]            level_out,
  output logic [7:0]                  rd_data,
  output logic                        ack_mismatch
);
  logic [LVL_W-1:0] win_level;
  logic [GW-1:0]    acc_group;

  irq_pri_search #(
    .NUM_GROUPS(NUM_GROUPS), .FIRST_GROUP(FIRST_GROUP), .LANES(LANES), .LVL_W(LVL_W)
  ) u_search (
    .req_vec(req_vec), .en_vec(en_vec), .lvl_vec(lvl_vec),
    .best_group(win_group), .best_level(win_level)
  );

  irq_pri_accept #(.GW(GW), .LVL_W(LVL_W)) u_accept (
    .clk(clk), .rst_n(rst_n),
    .best_group(win_group), .best_level(win_level),
    .ack_valid(ack_valid), .ack_level(ack_level),
    .level_q(level_out), .accepted_q(acc_group), .mismatch_q(ack_mismatch)
  );

  irq_pri_readback #(.NUM_GROUPS(NUM_GROUPS), .LANES(LANES), .AW(AW)) u_read (
    .req_vec(req_vec), .en_vec(en_vec), .accepted(acc_group),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/irq_pri_checker.sv
module irq_pri_checker #(
  parameter int GW          = 5,
  parameter int LVL_W       = 3,
  parameter int AW          = 3,
  parameter int FIRST_GROUP = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_valid,
  input logic [LVL_W-1:0] ack_level,
  input logic [GW-1:0]    win_group,
  input logic [LVL_W-1:0] win_level,
  input logic [LVL_W-1:0] level_out,
  input logic [GW-1:0]    acc_group,
  input logic             ack_mismatch,
  input logic [AW-1:0]    rd_addr,
  input logic [7:0]       rd_data
);
  localparam logic [LVL_W-1:0] IDLE = {LVL_W{1'b1}};

  assert_winner_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    win_group != '0 |-> (int'(win_group) >= FIRST_GROUP && win_level != IDLE));

  assert_idle_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_group == '0 |-> win_level == IDLE);

  assert_level_registered_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> level_out == $past(win_level));

  assert_accept_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> acc_group == $past(win_group));

  assert_read_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1:0] == 2'b00);

  assert_other_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr != '0 |-> rd_data == 8'h00);

  assert_mismatch_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_level != win_level) |=> ack_mismatch);

  assert_mismatch_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_mismatch |=> ack_mismatch);
endmodule

bind irq_priority_arbiter irq_pri_checker #(
  .GW(GW), .LVL_W(LVL_W), .AW(AW), .FIRST_GROUP(FIRST_GROUP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_level(ack_level),
  .win_group(win_group), .win_level(win_level), .level_out(level_out),
  .acc_group(acc_group), .ack_mismatch(ack_mismatch),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/sim_irq_priority_arbiter.sv
module sim_irq_priority_arbiter;
  localparam int NG = 31;
  localparam int FG = 2;
  localparam int NS = NG - FG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NG*4-1:0] req_vec = '0;
  logic [NG*4-1:0] en_vec = '0;
  logic [NS*3-1:0] lvl_vec = '0;
  logic ack_valid = 1'b0;
  logic [2:0] ack_level = 3'd0;
  logic [2:0] rd_addr = 3'd0;
  logic [4:0] win_group;
  logic [2:0] level_out;
  logic [7:0] rd_data;
  logic ack_mismatch;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  irq_priority_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .en_vec(en_vec), .lvl_vec(lvl_vec),
    .ack_valid(ack_valid), .ack_level(ack_level), .rd_addr(rd_addr),
    .win_group(win_group), .level_out(level_out), .rd_data(rd_data),
    .ack_mismatch(ack_mismatch)
  );

  // entry: {ga,la, gb,lb, gc,lc, exp_group, exp_level}; group 31 = unused slot
  localparam int NV = 9;
  localparam logic [31:0] VEC [NV] = '{
    {5'd31,3'd0, 5'd31,3'd0, 5'd31,3'd0, 5'd0, 3'd7},  // R3 nothing pending
    {5'd5, 3'd3, 5'd31,3'd0, 5'd31,3'd0, 5'd5, 3'd3},  // R2 single
    {5'd5, 3'd3, 5'd9, 3'd1, 5'd31,3'd0, 5'd9, 3'd1},  // R2 lower level wins
    {5'd7, 3'd2, 5'd4, 3'd2, 5'd31,3'd0, 5'd4, 3'd2},  // R4 tie
    {5'd1, 3'd0, 5'd10,3'd6, 5'd31,3'd0, 5'd10,3'd6},  // R1 group 1 excluded
    {5'd30,3'd0, 5'd2, 3'd0, 5'd31,3'd0, 5'd2, 3'd0},  // R4 tie at edges
    {5'd12,3'd7, 5'd31,3'd0, 5'd31,3'd0, 5'd0, 3'd7},  // R3 level 7 never wins
    {5'd30,3'd0, 5'd3, 3'd5, 5'd20,3'd4, 5'd30,3'd0},  // R2 highest group best
    {5'd0, 3'd0, 5'd31,3'd0, 5'd31,3'd0, 5'd0, 3'd7}   // R1 group 0 excluded
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_group(input int g, input int lvl);
    if (g < NG) begin
      req_vec[g*4] = 1'b1;
      en_vec[g*4]  = 1'b1;
      if (g >= FG) lvl_vec[(g-FG)*3 +: 3] = 3'(lvl);
    end
  endtask

  task automatic ack(input int lvl);
    @(negedge clk);
    ack_valid = 1'b1;
    ack_level = 3'(lvl);
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R5 reset level_out", int'(level_out), 7);
    check("R3 reset win_group", int'(win_group), 0);
    check("R9 reset mismatch", int'(ack_mismatch), 0);
    check("R7 reset read", int'(rd_data), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_vec = '0; en_vec = '0; lvl_vec = '0;
      set_group(int'(VEC[i][31:27]), int'(VEC[i][26:24]));
      set_group(int'(VEC[i][23:19]), int'(VEC[i][18:16]));
      set_group(int'(VEC[i][15:11]), int'(VEC[i][10:8]));
      #1;
      check($sformatf("R2/R4 vector %0d group", i), int'(win_group), int'(VEC[i][7:3]));
      @(negedge clk);
      check($sformatf("R5 vector %0d level", i), int'(level_out), int'(VEC[i][2:0]));
    end

    // R1: request without matching enable lane
    @(negedge clk);
    req_vec = '0; en_vec = '0; lvl_vec = '0;
    req_vec[6*4+0] = 1'b1; en_vec[6*4+1] = 1'b1; lvl_vec[(6-FG)*3 +: 3] = 3'd1;
    #1 check("R1 disjoint lanes", int'(win_group), 0);
    en_vec[6*4+0] = 1'b1;
    #1 check("R1 lane enabled", int'(win_group), 6);

    // R6/R7: accept group 9 at level 1
    @(negedge clk);
    req_vec = '0; en_vec = '0; lvl_vec = '0;
    set_group(9, 1); set_group(14, 4);
    ack(1);
    rd_addr = 3'd0;
    #1 check("R7 accepted read", int'(rd_data), 36);
    check("R9 matching ack", int'(ack_mismatch), 0);
    rd_addr = 3'd1;
    #1 check("R8 offset 1", int'(rd_data), 0);
    rd_addr = 3'd5;
    #1 check("R8 offset 5", int'(rd_data), 0);
    rd_addr = 3'd0;
    req_vec[9*4] = 1'b0;
    #1 check("R7 request vanished", int'(rd_data), 0);
    check("R6 new winner live", int'(win_group), 14);
    req_vec[9*4] = 1'b1;
    #1 check("R6 latch held", int'(rd_data), 36);

    // R9: mismatch when idle, then sticky
    @(negedge clk);
    req_vec = '0; en_vec = '0;
    ack(3);
    check("R9 mismatch set", int'(ack_mismatch), 1);
    #1 check("R6 accepted idle group", int'(rd_data), 0);
    ack(7);
    check("R9 mismatch sticky", int'(ack_mismatch), 1);
    rst_n = 1'b0;
    #1 check("R9 reset clears", int'(ack_mismatch), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule